// File: doc/BRIEF.md
# Instruction Control Decoder

This block turns the operation field of a fixed-width 32-bit instruction into the steering and enable signals of a single-cycle datapath. That datapath runs a small set of instructions: register add, subtract, AND, OR and set-less-than; word load; word store; add-immediate; branch-if-equal; and an unconditional jump. The block is purely combinational. Its outputs settle from the 6-bit opcode (instruction bits [31:26]) and the 6-bit function field (instruction bits [5:0]) within the same cycle. The datapath register file and memories consume these outputs at the next clock edge.

Decoding runs in two levels. The first level looks only at the opcode. It sets the destination, operand-source, write-back and enable controls, plus a 2-bit ALU class. The second level turns that class into a 4-bit ALU operation code. It reads the function field only when the class says "register format". An opcode outside the set, or a register-format instruction with an unknown function field, cannot change architectural state: it drives no register write, no memory write, no branch and no jump.

There is no data stream here, so there is no valid/ready handshake. Every pin is a plain control level.

Top module: `ctl_decode`

## Requirements
- R1: Opcode 6'h00 with function 6'h20 (add), 6'h22 (sub), 6'h24 (and), 6'h25 (or) or 6'h2A (slt) drives the following: `dst_sel_rd`=1, `src_sel_imm`=0, `wb_from_mem`=0, `reg_we`=1, and `mem_re`, `mem_we`, `is_branch`, `is_jump` all 0. It also drives `alu_class`=2'b10.
- R2: The ALU codes for register format are: and 4'b0000, or 4'b0001, add 4'b0010, sub 4'b0110, slt 4'b0111.
- R3: Opcode 6'h23 (load) drives `src_sel_imm`=1, `wb_from_mem`=1, `reg_we`=1, `mem_re`=1 and `dst_sel_rd`=0. It drives `mem_we`, `is_branch` and `is_jump` to 0, and `alu_class`=2'b00 with ALU code 4'b0010.
- R4: Opcode 6'h2B (store) drives `src_sel_imm`=1 and `mem_we`=1. It drives `reg_we`, `mem_re`, `wb_from_mem`, `dst_sel_rd`, `is_branch` and `is_jump` to 0, and `alu_class`=2'b00 with ALU code 4'b0010.
- R5: Opcode 6'h04 (branch-if-equal) drives `is_branch`=1 and `alu_class`=2'b01 with ALU code 4'b0110. All other outputs are 0.
- R6: Opcode 6'h08 (add-immediate) drives `src_sel_imm`=1 and `reg_we`=1. It drives `dst_sel_rd`, `wb_from_mem`, `mem_re`, `mem_we`, `is_branch` and `is_jump` to 0, and `alu_class`=2'b00 with ALU code 4'b0010.
- R7: Opcode 6'h02 (jump) drives `is_jump`=1 and every other single-bit output to 0, with `alu_class`=2'b00 and ALU code 4'b0010.
- R8: Any other opcode drives every single-bit output to 0, with `alu_class`=2'b00 and ALU code 4'b0010.
- R9: Opcode 6'h00 with any function value other than the five in R1 drives `reg_we`=0 and ALU code 4'b1111. `dst_sel_rd`=1 and `alu_class`=2'b10 are kept.
- R10: For every opcode other than 6'h00, the function field has no effect on any output.
- R11: `mem_we` and `reg_we` are never 1 together. `is_branch` and `is_jump` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode | input | 6 | Instruction bits [31:26] |
| funct | input | 6 | Instruction bits [5:0] |
| dst_sel_rd | output | 1 | 1: write destination is bits [15:11]; 0: bits [20:16] |
| src_sel_imm | output | 1 | 1: second ALU operand is the extended immediate |
| wb_from_mem | output | 1 | 1: register write data comes from data memory |
| reg_we | output | 1 | Register file write enable |
| mem_re | output | 1 | Data memory read enable |
| mem_we | output | 1 | Data memory write enable |
| is_branch | output | 1 | Conditional branch on equality |
| is_jump | output | 1 | Unconditional jump |
| alu_class | output | 2 | 00 add, 01 subtract, 10 decode function field |
| alu_code | output | 4 | ALU operation code |

## Verification
A vector table drives each of the ten supported instructions and checks the full output word against a hand-built expected word. This separates instructions that differ in a single control bit, such as load against add-immediate or store against load. Some rows pair a non-register opcode with a function value that would mean something for register format. These rows show that the second level ignores the function field outside register format. Full sweeps of all 64 opcodes and all 64 function values then separate the recognised codes from the rest. They confirm that every unrecognised value leaves the state-changing enables low.

// File: rtl/ctl_pkg.sv
package ctl_pkg;
  localparam int OP_W   = 6;
  localparam int FN_W   = 6;
  localparam int CODE_W = 4;

  typedef enum logic [1:0] {
    CLS_ADD  = 2'b00,
    CLS_SUB  = 2'b01,
    CLS_FUNC = 2'b10
  } alu_class_t;

  localparam logic [OP_W-1:0] OPC_REG   = 6'h00;
  localparam logic [OP_W-1:0] OPC_JMP   = 6'h02;
  localparam logic [OP_W-1:0] OPC_BEQ   = 6'h04;
  localparam logic [OP_W-1:0] OPC_ADDI  = 6'h08;
  localparam logic [OP_W-1:0] OPC_LOAD  = 6'h23;
  localparam logic [OP_W-1:0] OPC_STORE = 6'h2B;

  localparam logic [FN_W-1:0] FN_ADD = 6'h20;
  localparam logic [FN_W-1:0] FN_SUB = 6'h22;
  localparam logic [FN_W-1:0] FN_AND = 6'h24;
  localparam logic [FN_W-1:0] FN_OR  = 6'h25;
  localparam logic [FN_W-1:0] FN_SLT = 6'h2A;

  localparam logic [CODE_W-1:0] AC_AND = 4'b0000;
  localparam logic [CODE_W-1:0] AC_OR  = 4'b0001;
  localparam logic [CODE_W-1:0] AC_ADD = 4'b0010;
  localparam logic [CODE_W-1:0] AC_SUB = 4'b0110;
  localparam logic [CODE_W-1:0] AC_SLT = 4'b0111;
  localparam logic [CODE_W-1:0] AC_BAD = {CODE_W{1'b1}};

  typedef struct packed {
    logic       dst_rd;
    logic       src_imm;
    logic       wb_mem;
    logic       reg_we;
    logic       mem_re;
    logic       mem_we;
    logic       branch;
    logic       jump;
    alu_class_t cls;
  } ctl_word_t;
endpackage

// File: rtl/opdec_main.sv
module opdec_main
  import ctl_pkg::*;
(
  input  logic [OP_W-1:0] opcode,
  output ctl_word_t       ctl
);
  always_comb begin
    ctl = '0;
    ctl.cls = CLS_ADD;
    unique case (opcode)
      OPC_REG: begin
        ctl.dst_rd = 1'b1;
        ctl.reg_we = 1'b1;
        ctl.cls    = CLS_FUNC;
      end
      OPC_LOAD: begin
        ctl.src_imm = 1'b1;
        ctl.wb_mem  = 1'b1;
        ctl.reg_we  = 1'b1;
        ctl.mem_re  = 1'b1;
      end
      OPC_STORE: begin
        ctl.src_imm = 1'b1;
        ctl.mem_we  = 1'b1;
      end
      OPC_BEQ: begin
        ctl.branch = 1'b1;
        ctl.cls    = CLS_SUB;
      end
      OPC_ADDI: begin
        ctl.src_imm = 1'b1;
        ctl.reg_we  = 1'b1;
      end
      OPC_JMP: ctl.jump = 1'b1;
      default: ctl = '0;
    endcase
    // R11: store and register write never overlap
    a_r11_we_excl: assert (!(ctl.mem_we && ctl.reg_we))
      else $error("a_r11_we_excl");
    // R11: branch and jump never overlap
    a_r11_flow_excl: assert (!(ctl.branch && ctl.jump))
      else $error("a_r11_flow_excl");
    // R3: a memory read always routes memory data to write-back
    a_r3_load_path: assert (!ctl.mem_re || (ctl.wb_mem && ctl.reg_we))
      else $error("a_r3_load_path");
  end
endmodule

// File: rtl/opdec_alu.sv
module opdec_alu
  import ctl_pkg::*;
(
  input  alu_class_t        cls,
  input  logic [FN_W-1:0]   funct,
  output logic [CODE_W-1:0] code,
  output logic              funct_ok
);
  always_comb begin
    funct_ok = 1'b1;
    code     = AC_BAD;
    unique case (cls)
      CLS_ADD: code = AC_ADD;
      CLS_SUB: code = AC_SUB;
      CLS_FUNC: begin
        unique case (funct)
          FN_ADD:  code = AC_ADD;
          FN_SUB:  code = AC_SUB;
          FN_AND:  code = AC_AND;
          FN_OR:   code = AC_OR;
          FN_SLT:  code = AC_SLT;
          default: begin
            code     = AC_BAD;
            funct_ok = 1'b0;
          end
        endcase
      end
      default: begin
        code     = AC_BAD;
        funct_ok = 1'b0;
      end
    endcase
    // R10: outside register format the function field cannot mark an error
    a_r10_funct_gate: assert (cls == CLS_FUNC || funct_ok)
      else $error("a_r10_funct_gate");
    // R9: the reserved code appears only with a rejected function value
    a_r9_bad_code: assert ((code == AC_BAD) == !funct_ok)
      else $error("a_r9_bad_code");
  end
endmodule

// File: rtl/ctl_decode.sv
module ctl_decode
  import ctl_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output logic       dst_sel_rd,
  output logic       src_sel_imm,
  output logic       wb_from_mem,
  output logic       reg_we,
  output logic       mem_re,
  output logic       mem_we,
  output logic       is_branch,
  output logic       is_jump,
  output logic [1:0] alu_class,
  output logic [3:0] alu_code
);
  ctl_word_t         ctl;
  logic [CODE_W-1:0] code;
  logic              funct_ok;

  opdec_main u_main (
    .opcode (opcode),
    .ctl    (ctl)
  );

  opdec_alu u_alu (
    .cls      (ctl.cls),
    .funct    (funct),
    .code     (code),
    .funct_ok (funct_ok)
  );

  always_comb begin
    dst_sel_rd  = ctl.dst_rd;
    src_sel_imm = ctl.src_imm;
    wb_from_mem = ctl.wb_mem;
    reg_we      = ctl.reg_we && funct_ok;
    mem_re      = ctl.mem_re;
    mem_we      = ctl.mem_we;
    is_branch   = ctl.branch;
    is_jump     = ctl.jump;
    alu_class   = ctl.cls;
    alu_code    = code;
    // R9: a rejected function value never reaches the register write enable
    a_r9_no_bad_write: assert (!(reg_we && !funct_ok))
      else $error("a_r9_no_bad_write");
  end
endmodule

// File: tb/sim_ctl_decode.sv
`timescale 1ns/1ps
module sim_ctl_decode;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic [5:0] opcode, funct;
  logic dst_sel_rd, src_sel_imm, wb_from_mem, reg_we, mem_re, mem_we, is_branch, is_jump;
  logic [1:0] alu_class;
  logic [3:0] alu_code;

  ctl_decode u0 (.*);

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // {opcode, funct, dst,imm,wbm,rwe,mre,mwe,br,jmp, class[1:0], code[3:0]}
  localparam int NV = 15;
  localparam logic [25:0] VEC [NV] = '{
    {6'h00, 6'h20, 8'b1001_0000, 2'b10, 4'b0010},  // R1 add
    {6'h00, 6'h22, 8'b1001_0000, 2'b10, 4'b0110},  // R1 sub
    {6'h00, 6'h24, 8'b1001_0000, 2'b10, 4'b0000},  // R2 and
    {6'h00, 6'h25, 8'b1001_0000, 2'b10, 4'b0001},  // R2 or
    {6'h00, 6'h2A, 8'b1001_0000, 2'b10, 4'b0111},  // R2 slt
    {6'h23, 6'h00, 8'b0111_1000, 2'b00, 4'b0010},  // R3 load
    {6'h2B, 6'h00, 8'b0100_0100, 2'b00, 4'b0010},  // R4 store
    {6'h04, 6'h00, 8'b0000_0010, 2'b01, 4'b0110},  // R5 beq
    {6'h08, 6'h00, 8'b0101_0000, 2'b00, 4'b0010},  // R6 addi
    {6'h02, 6'h00, 8'b0000_0001, 2'b00, 4'b0010},  // R7 jump
    {6'h3F, 6'h20, 8'b0000_0000, 2'b00, 4'b0010},  // R8 unknown op
    {6'h00, 6'h00, 8'b1000_0000, 2'b10, 4'b1111},  // R9 bad funct
    {6'h23, 6'h22, 8'b0111_1000, 2'b00, 4'b0010},  // R10 load, funct ignored
    {6'h04, 6'h25, 8'b0000_0010, 2'b01, 4'b0110},  // R10 beq, funct ignored
    {6'h2B, 6'h3F, 8'b0100_0100, 2'b00, 4'b0010}   // R10 store, funct ignored
  };

  function automatic logic [13:0] outword();
    return {dst_sel_rd, src_sel_imm, wb_from_mem, reg_we, mem_re, mem_we,
            is_branch, is_jump, alu_class, alu_code};
  endfunction

  task automatic check(input string req, input logic [13:0] act, input logic [13:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s op=%h fn=%h actual=%b expected=%b", req, opcode, funct, act, exp);
    end
  endtask

  task automatic apply(input logic [5:0] op, input logic [5:0] fn);
    @(negedge clk);
    opcode = op;
    funct  = fn;
    #1;
  endtask

  function automatic bit known_op(input logic [5:0] op);
    return op inside {6'h00, 6'h02, 6'h04, 6'h08, 6'h23, 6'h2B};
  endfunction

  function automatic bit known_fn(input logic [5:0] fn);
    return fn inside {6'h20, 6'h22, 6'h24, 6'h25, 6'h2A};
  endfunction

  initial begin
    opcode = 6'h3F;
    funct  = 6'h00;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // Initial state, unknown opcode: R8
    apply(6'h3F, 6'h00);
    check("R8", outword(), {8'b0, 2'b00, 4'b0010});

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][25:20], VEC[i][19:14]);
      check(i < 5 ? "R1/R2" : i < 11 ? "R3-R8" : i == 11 ? "R9" : "R10",
            outword(), VEC[i][13:0]);
    end

    // R8: sweep all opcodes, unknown ones change no state
    for (int op = 0; op < 64; op++) begin
      apply(6'(op), 6'h20);
      if (!known_op(6'(op)))
        check("R8", outword(), {8'b0, 2'b00, 4'b0010});
      // R11: exclusive enables on every opcode
      check("R11", {12'b0, mem_we & reg_we, is_branch & is_jump}, 14'b0);
    end

    // R9: sweep all function values in register format
    for (int fn = 0; fn < 64; fn++) begin
      apply(6'h00, 6'(fn));
      if (!known_fn(6'(fn)))
        check("R9", {reg_we, alu_code, dst_sel_rd, alu_class},
              {1'b0, 4'b1111, 1'b1, 2'b10});
      else
        check("R1", {reg_we, dst_sel_rd, alu_class}, {1'b1, 1'b1, 2'b10});
    end

    // R10: addi under every function value
    for (int fn = 0; fn < 64; fn++) begin
      apply(6'h08, 6'(fn));
      check("R10", outword(), {8'b0101_0000, 2'b00, 4'b0010});
    end

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule